// File: doc/BRIEF.md
# PCI Target Data-Phase Termination Controller

This block is the control half of a PCI target. It watches FRAME# and IRDY# from the bus master. When the master starts a transaction that the local address decoder claims, it asserts DEVSEL# at medium decode timing. It then paces every data phase with TRDY# and STOP#. The local back end steers the pacing with a small request code on each clock: wait, ready, ready-for-the-last-word, stop, or fatal. The controller turns these requests into normal transfers or into one of three target-initiated endings: retry, disconnect or target abort. Two latency counters force a retry or a disconnect when the back end stalls for too long.

The outputs are active-low control levels plus one shared output enable. The enable models the tri-state buffers: the pins are driven high for one clock after the final data phase, and the enable drops on the clock after that. Two further outputs let a checker or a scoreboard follow the transaction. A one-clock pulse marks each completed data phase. A code names the way the most recent transaction was terminated.

Top module: `pci_tgt_term`

## Requirements
- R1: While reset is active and after it is released, `trdy_n`, `stop_n` and `devsel_n` are high, `ctl_oe` is 0, `phase_done` is 0 and `term_type` is 0. Whenever `ctl_oe` is 0, the three control outputs are high.
- R2: The address phase is the clock in which FRAME# first goes low. When `hit` is 1 in that clock, `devsel_n` goes low in the second clock after it (DECODE_CLKS = 2) and `ctl_oe` goes to 1 together with it. When `hit` is 0, the block never drives the bus for that transaction. TRDY# is low only while DEVSEL# is low.
- R3: A data phase completes on a rising edge where `irdy_n` is low and either `trdy_n` or `stop_n` is low. `phase_done` is 1 for exactly the one clock after each such edge. A word moves on each edge where `irdy_n` and `trdy_n` are both low.
- R4: Once TRDY# or STOP# is low, TRDY#, STOP# and DEVSEL# keep their values until the current data phase completes. Back-end requests made during that time have no effect.
- R5: Once STOP# is low, it stays low until a data phase completes with FRAME# high. If a phase completes with STOP# low and FRAME# still low, TRDY# returns high and STOP# stays low.
- R6: After a data phase completes with FRAME# high, the next clock has `ctl_oe` = 1 with all three control outputs high. The clock after that has `ctl_oe` = 0.
- R7: Retry. Request code 3 (stop) given before any word of the transaction has moved drives STOP# low, TRDY# high and DEVSEL# low, and sets `term_type` to 1.
- R8: Disconnect with data. Request code 2 (last) drives TRDY# and STOP# low together, and sets `term_type` to 2. Exactly one more word moves.
- R9: Disconnect without data. Request code 3 given after at least one word has moved drives STOP# low with TRDY# high, and sets `term_type` to 2.
- R10: Target abort. Request code 4 (fatal) drives STOP# low and DEVSEL# high, and sets `term_type` to 3. Request code 1 (ready) drives TRDY# low. Code 0 and the unused codes 5 to 7 mean wait.
- R11: If no word has moved yet and the back end asks to wait for INIT_LAT consecutive clocks after DEVSEL# goes low, STOP# goes low INIT_LAT clocks after DEVSEL#, as a retry (`term_type` 1).
- R12: If a word has moved and a new phase is left waiting for SUB_LAT consecutive clocks, STOP# goes low SUB_LAT clocks after the previous phase completed, as a disconnect (`term_type` 2).
- R13: `term_type` keeps its value after the transaction ends and returns to 0 when the next transaction is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | FRAME# from the master |
| irdy_n | input | 1 | IRDY# from the master |
| hit | input | 1 | Address decoder claim, valid in the address phase |
| be_req | input | 3 | Back-end request: 0 wait, 1 ready, 2 last, 3 stop, 4 fatal |
| trdy_n | output | 1 | TRDY# level |
| stop_n | output | 1 | STOP# level |
| devsel_n | output | 1 | DEVSEL# level |
| ctl_oe | output | 1 | Output enable for TRDY#, STOP# and DEVSEL# |
| phase_done | output | 1 | One-clock pulse per completed data phase |
| term_type | output | 2 | Termination code: 0 none, 1 retry, 2 disconnect, 3 abort |

## Verification
The bench builds the block with INIT_LAT = 4 and SUB_LAT = 3, and keeps medium decode (DECODE_CLKS = 2). The small limits let both latency timeouts fire within a few clocks of a short transaction. The exact clock at which a forced retry or disconnect appears can then be checked against the limit. With the default limits these paths would need long stalls and would hide among ordinary wait states.

// File: rtl/pci_tgt_pkg.sv
// Shared types for the PCI target termination controller.
// Assumes: request and termination codes are fixed by the requirements.
package pci_tgt_pkg;

    typedef enum logic [2:0] {
        BE_WAIT  = 3'd0,
        BE_READY = 3'd1,
        BE_LAST  = 3'd2,
        BE_STOP  = 3'd3,
        BE_FATAL = 3'd4
    } be_req_e;

    typedef enum logic [1:0] {
        TT_NONE  = 2'd0,
        TT_RETRY = 2'd1,
        TT_DISC  = 2'd2,
        TT_ABORT = 2'd3
    } term_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DATA    = 2'd1,
        ST_RELEASE = 2'd2
    } tgt_state_e;

    typedef struct packed {
        logic trdy_n;
        logic stop_n;
        logic devsel_n;
    } bus_ctl_t;

endpackage

// File: rtl/pci_tgt_claim.sv
// Address-phase detector and decode-delay pipeline.
// Finds the clock in which FRAME# first falls and, if the decoder hit,
// raises claim DECODE_CLKS-1 clocks later so that DEVSEL# lands in the
// clock DECODE_CLKS after the address phase.
// Assumes: hit is valid in the address phase; armed is high only while
// the sequencer is idle.
module pci_tgt_claim #(
    parameter int DECODE_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic hit,
    input  logic armed,
    output logic claim
);

    logic frame_q;
    logic addr_hit;

    // Remember FRAME# of the previous clock to spot its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= 1'b1;
        else        frame_q <= frame_n;
    end

    assign addr_hit = armed && !frame_n && frame_q && hit;

    generate
        if (DECODE_CLKS <= 1) begin : g_fast
            assign claim = addr_hit;
        end else begin : g_delayed
            localparam int STAGES = DECODE_CLKS - 1;
            logic [STAGES-1:0] pipe_q;

            // First stage captures a decoded hit in the address phase.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[0] <= 1'b0;
                else        pipe_q[0] <= addr_hit;
            end

            for (genvar i = 1; i < STAGES; i++) begin : g_stage
                // Each further stage adds one clock of decode time.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe_q[i] <= 1'b0;
                    else        pipe_q[i] <= pipe_q[i-1];
                end
            end

            assign claim = pipe_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pci_tgt_latency.sv
// Wait-state counter for the two latency limits.
// Counts consecutive clocks in which the target holds a phase open
// without TRDY# or STOP#. It flags expiry on the clock whose edge must
// assert STOP#. The limit in use depends on whether data has moved.
// Assumes: INIT_LAT and SUB_LAT are at least 1.
module pci_tgt_latency #(
    parameter int INIT_LAT = 16,
    parameter int SUB_LAT  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic after_data,
    output logic expired
);

    localparam int MAXL = (INIT_LAT > SUB_LAT) ? INIT_LAT : SUB_LAT;
    localparam int CW   = $clog2(MAXL + 1);
    localparam logic [CW-1:0] INIT_M1 = CW'(INIT_LAT - 1);
    localparam logic [CW-1:0] SUB_M1  = CW'(SUB_LAT - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit_m1;

    assign limit_m1 = after_data ? SUB_M1 : INIT_M1;
    assign expired  = run && (cnt_q == limit_m1);

    // Count waiting clocks; any non-waiting clock restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!run)     cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/pci_tgt_phase_seq.sv
// Data-phase sequencer: owns TRDY#, STOP#, DEVSEL# and their enable.
// Applies the back-end request at each phase start. It holds the
// signals until the phase completes, keeps STOP# until FRAME# has gone
// high, and releases and then tri-states the pins after the last phase.
// Assumes: the master follows the bus rules for FRAME# and IRDY#.
module pci_tgt_phase_seq
    import pci_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_n,
    input  logic     irdy_n,
    input  logic     claim,
    input  be_req_e  be_req,
    input  logic     lat_expired,
    output bus_ctl_t ctl,
    output logic     drive,
    output logic     phase_done,
    output term_e    term,
    output logic     armed,
    output logic     lat_run,
    output logic     lat_after_data
);

    tgt_state_e state_q, state_d;
    bus_ctl_t   ctl_q, ctl_d;
    term_e      term_q, term_d;
    logic       moved_q, moved_d;
    logic       done_q;

    logic pending;
    logic done;
    logic xfer;
    logic moved_now;
    logic master_gone;

    assign pending     = !ctl_q.trdy_n || !ctl_q.stop_n;
    assign done        = (state_q == ST_DATA) && !irdy_n && pending;
    assign xfer        = done && !ctl_q.trdy_n;
    assign moved_now   = moved_q || xfer;
    assign master_gone = frame_n && irdy_n;

    assign lat_run        = (state_q == ST_DATA) && !pending && !master_gone;
    assign lat_after_data = moved_q;

    // Next-state, next-signal and termination-code decision.
    always_comb begin
        state_d = state_q;
        ctl_d   = ctl_q;
        term_d  = term_q;
        moved_d = moved_now;
        unique case (state_q)
            ST_IDLE: begin
                ctl_d   = '1;
                moved_d = 1'b0;
                if (claim) begin
                    state_d        = ST_DATA;
                    ctl_d.devsel_n = 1'b0;
                    term_d         = TT_NONE;
                end
            end
            ST_DATA: begin
                if (pending && !done) begin
                    ctl_d = ctl_q;
                end else if (done && frame_n) begin
                    state_d = ST_RELEASE;
                    ctl_d   = '1;
                end else if (done && !ctl_q.stop_n) begin
                    ctl_d.trdy_n = 1'b1;
                end else if (!pending && master_gone) begin
                    state_d = ST_RELEASE;
                    ctl_d   = '1;
                end else begin
                    ctl_d.trdy_n = 1'b1;
                    ctl_d.stop_n = 1'b1;
                    unique case (be_req)
                        BE_READY: ctl_d.trdy_n = 1'b0;
                        BE_LAST: begin
                            ctl_d.trdy_n = 1'b0;
                            ctl_d.stop_n = 1'b0;
                            term_d       = TT_DISC;
                        end
                        BE_STOP: begin
                            ctl_d.stop_n = 1'b0;
                            term_d       = moved_now ? TT_DISC : TT_RETRY;
                        end
                        BE_FATAL: begin
                            ctl_d.stop_n   = 1'b0;
                            ctl_d.devsel_n = 1'b1;
                            term_d         = TT_ABORT;
                        end
                        default: begin
                            if (lat_expired) begin
                                ctl_d.stop_n = 1'b0;
                                term_d       = moved_now ? TT_DISC : TT_RETRY;
                            end
                        end
                    endcase
                end
            end
            ST_RELEASE: begin
                state_d = ST_IDLE;
                ctl_d   = '1;
            end
            default: begin
                state_d = ST_IDLE;
                ctl_d   = '1;
            end
        endcase
    end

    // Register state, control levels, code and the phase-done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl_q   <= '1;
            term_q  <= TT_NONE;
            moved_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_d;
            term_q  <= term_d;
            moved_q <= moved_d;
            done_q  <= done;
        end
    end

    assign ctl        = ctl_q;
    assign drive      = (state_q != ST_IDLE);
    assign phase_done = done_q;
    assign term       = term_q;
    assign armed      = (state_q == ST_IDLE);

endmodule

// File: rtl/pci_tgt_term.sv
// Top of the PCI target termination controller.
// Joins the claim detector, the latency counter and the phase sequencer.
// It presents active-low control levels plus a shared output enable.
// Assumes: the pad logic tri-states TRDY#, STOP# and DEVSEL# while
// ctl_oe is low.
module pci_tgt_term
    import pci_tgt_pkg::*;
#(
    parameter int DECODE_CLKS = 2,
    parameter int INIT_LAT    = 16,
    parameter int SUB_LAT     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_n,
    input  logic       irdy_n,
    input  logic       hit,
    input  logic [2:0] be_req,
    output logic       trdy_n,
    output logic       stop_n,
    output logic       devsel_n,
    output logic       ctl_oe,
    output logic       phase_done,
    output logic [1:0] term_type
);

    logic     claim;
    logic     armed;
    logic     lat_run;
    logic     lat_after_data;
    logic     lat_expired;
    bus_ctl_t ctl;
    term_e    term;

    pci_tgt_claim #(
        .DECODE_CLKS(DECODE_CLKS)
    ) u_claim (
        .clk    (clk),
        .rst_n  (rst_n),
        .frame_n(frame_n),
        .hit    (hit),
        .armed  (armed),
        .claim  (claim)
    );

    pci_tgt_latency #(
        .INIT_LAT(INIT_LAT),
        .SUB_LAT (SUB_LAT)
    ) u_latency (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (lat_run),
        .after_data(lat_after_data),
        .expired   (lat_expired)
    );

    pci_tgt_phase_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_n       (frame_n),
        .irdy_n        (irdy_n),
        .claim         (claim),
        .be_req        (be_req_e'(be_req)),
        .lat_expired   (lat_expired),
        .ctl           (ctl),
        .drive         (ctl_oe),
        .phase_done    (phase_done),
        .term          (term),
        .armed         (armed),
        .lat_run       (lat_run),
        .lat_after_data(lat_after_data)
    );

    assign trdy_n    = ctl.trdy_n;
    assign stop_n    = ctl.stop_n;
    assign devsel_n  = ctl.devsel_n;
    assign term_type = term;

endmodule

// File: rtl/pci_tgt_term_chk.sv
// Protocol checker for pci_tgt_term, attached by bind.
// Checks the hold, release and completion rules at the block's ports.
module pci_tgt_term_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic       irdy_n,
    input logic       trdy_n,
    input logic       stop_n,
    input logic       devsel_n,
    input logic       ctl_oe,
    input logic       phase_done,
    input logic [1:0] term_type
);

    AST_IDLE_PINS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_oe |-> (trdy_n && stop_n && devsel_n)); // R1

    AST_TRDY_WITH_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && !irdy_n && (!trdy_n || !stop_n)) |=> phase_done); // R3

    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_oe && !irdy_n && (!trdy_n || !stop_n)) |=> !phase_done); // R3

    AST_HOLD_OPEN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && (!trdy_n || !stop_n) && irdy_n)
        |=> ($stable(trdy_n) && $stable(stop_n) && $stable(devsel_n))); // R4

    AST_STOP_UNTIL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && !stop_n && !(!irdy_n && frame_n)) |=> !stop_n); // R5

    AST_RELEASE_THEN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && !irdy_n && (!trdy_n || !stop_n) && frame_n)
        |=> (ctl_oe && trdy_n && stop_n && devsel_n) ##1 !ctl_oe); // R6

    AST_ABORT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && !stop_n && devsel_n) |-> (term_type == 2'd3)); // R10

endmodule

bind pci_tgt_term pci_tgt_term_chk u_chk (.*);

// File: tb/tb_pci_tgt_term.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_pci_tgt_term;

    localparam logic [2:0] RQ_WAIT  = 3'd0;
    localparam logic [2:0] RQ_READY = 3'd1;
    localparam logic [2:0] RQ_LAST  = 3'd2;
    localparam logic [2:0] RQ_STOP  = 3'd3;
    localparam logic [2:0] RQ_FATAL = 3'd4;
    localparam int NEVER = 1000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_n;
    logic       irdy_n;
    logic       hit;
    logic [2:0] be_req;
    logic       trdy_n, stop_n, devsel_n, ctl_oe, phase_done;
    logic [1:0] term_type;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pci_tgt_term #(
        .DECODE_CLKS(2),
        .INIT_LAT   (4),
        .SUB_LAT    (3)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .hit       (hit),
        .be_req    (be_req),
        .trdy_n    (trdy_n),
        .stop_n    (stop_n),
        .devsel_n  (devsel_n),
        .ctl_oe    (ctl_oe),
        .phase_done(phase_done),
        .term_type (term_type)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Master model: runs one transaction and reports what it saw.
    task automatic run_txn(input int nwords, input int switch_at,
                           input logic [2:0] first_req, input logic [2:0] later_req,
                           input logic hit_v,
                           output int xfers, output int phases, output int pulses,
                           output int dev_cyc, output int stop_cyc,
                           output int abort_seen, output int oe_seen,
                           output int rel_ok, output int last_term);
        int  cyc = 0;
        int  left = nwords;
        bit  fin = 0;
        bit  comp, xf, saw_stop, fr;
        xfers = 0; phases = 0; pulses = 0; dev_cyc = -1; stop_cyc = -1;
        abort_seen = 0; oe_seen = 0; rel_ok = 0;
        @(posedge clk); #1;
        be_req = first_req; hit = hit_v; frame_n = 1'b0; irdy_n = 1'b1;
        while (!fin && cyc < 64) begin
            @(negedge clk);
            if (phase_done) pulses++;
            if (ctl_oe) oe_seen = 1;
            if (!devsel_n && dev_cyc < 0) dev_cyc = cyc;
            if (!stop_n && stop_cyc < 0) stop_cyc = cyc;
            if (ctl_oe && !stop_n && devsel_n) abort_seen = 1;
            comp     = ctl_oe && !irdy_n && (!trdy_n || !stop_n);
            xf       = comp && !trdy_n;
            saw_stop = !stop_n;
            fr       = frame_n;
            @(posedge clk); #1;
            cyc++;
            hit = 1'b0;
            if (comp) phases++;
            if (xf) begin xfers++; left--; end
            if (xfers >= switch_at) be_req = later_req;
            if (comp && fr) begin
                fin = 1; frame_n = 1'b1; irdy_n = 1'b1;
            end else if (dev_cyc < 0 && cyc >= 6) begin
                fin = 1; frame_n = 1'b1; irdy_n = 1'b1;
            end else begin
                irdy_n = 1'b0;
                if (saw_stop || left <= 1) frame_n = 1'b1;
            end
        end
        @(negedge clk);
        if (phase_done) pulses++;
        rel_ok = (ctl_oe && trdy_n && stop_n && devsel_n) ? 1 : 0;
        if (dev_cyc < 0) rel_ok = (!ctl_oe) ? 1 : 0;
        @(negedge clk);
        if (ctl_oe) rel_ok = 0;
        last_term = int'(term_type);
        be_req = RQ_WAIT;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; hit = 1'b0; be_req = RQ_WAIT;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "oe in reset", ctl_oe, 0);
        chk("R1", "pins in reset", {trdy_n, stop_n, devsel_n}, 7);
        #1 rst_n = 1'b1;
        idle(2);
        @(negedge clk);
        chk("R1", "oe after reset", ctl_oe, 0);
        chk("R1", "pins after reset", {trdy_n, stop_n, devsel_n}, 7);
        chk("R1", "phase_done after reset", phase_done, 0);
        chk("R1", "term after reset", term_type, 0);
    endtask

    task automatic t_burst(input int n, input string tag);
        int x, p, pu, dc, sc, ab, oe, rl, tt;
        run_txn(n, NEVER, RQ_READY, RQ_READY, 1'b1, x, p, pu, dc, sc, ab, oe, rl, tt);
        chk("R2", {tag, " devsel clock"}, dc, 2);
        chk("R3", {tag, " words moved"}, x, n);
        chk("R3", {tag, " done pulses"}, pu, n);
        chk("R5", {tag, " no stop"}, sc, -1);
        chk("R6", {tag, " release then float"}, rl, 1);
        chk("R13", {tag, " term none"}, tt, 0);
    endtask

    task automatic t_retry();
        int x, p, pu, dc, sc, ab, oe, rl, tt;
        run_txn(8, NEVER, RQ_STOP, RQ_STOP, 1'b1, x, p, pu, dc, sc, ab, oe, rl, tt);
        chk("R7", "retry stop clock", sc, 3);
        chk("R7", "retry words", x, 0);
        chk("R7", "retry keeps devsel", ab, 0);
        chk("R5", "retry phases", p, 2);
        chk("R3", "retry pulses", pu, 2);
        chk("R6", "retry release", rl, 1);
        chk("R7", "retry term", tt, 1);
    endtask

    task automatic t_disc_data();
        int x, p, pu, dc, sc, ab, oe, rl, tt;
        run_txn(8, 2, RQ_READY, RQ_LAST, 1'b1, x, p, pu, dc, sc, ab, oe, rl, tt);
        chk("R8", "disc-with-data stop clock", sc, 6);
        chk("R8", "disc-with-data words", x, 4);
        chk("R5", "disc-with-data phases", p, 5);
        chk("R6", "disc-with-data release", rl, 1);
        chk("R8", "disc-with-data term", tt, 2);
    endtask

    task automatic t_disc_nodata();
        int x, p, pu, dc, sc, ab, oe, rl, tt;
        run_txn(8, 2, RQ_READY, RQ_STOP, 1'b1, x, p, pu, dc, sc, ab, oe, rl, tt);
        chk("R9", "disc-no-data stop clock", sc, 6);
        chk("R9", "disc-no-data words", x, 3);
        chk("R3", "disc-no-data pulses", pu, 5);
        chk("R9", "disc-no-data term", tt, 2);
    endtask

    task automatic t_abort(input int sw, input int exp_x, input int exp_sc);
        int x, p, pu, dc, sc, ab, oe, rl, tt;
        logic [2:0] first;
        first = (sw == 0) ? RQ_FATAL : RQ_READY;
        run_txn(8, sw, first, RQ_FATAL, 1'b1, x, p, pu, dc, sc, ab, oe, rl, tt);
        chk("R10", "abort stop clock", sc, exp_sc);
        chk("R10", "abort devsel high with stop", ab, 1);
        chk("R10", "abort words", x, exp_x);
        chk("R6", "abort release", rl, 1);
        chk("R10", "abort term", tt, 3);
    endtask

    task automatic t_init_timeout();
        int x, p, pu, dc, sc, ab, oe, rl, tt;
        run_txn(8, NEVER, RQ_WAIT, RQ_WAIT, 1'b1, x, p, pu, dc, sc, ab, oe, rl, tt);
        chk("R11", "initial timeout stop clock", sc, 6);
        chk("R11", "initial timeout words", x, 0);
        chk("R11", "initial timeout term", tt, 1);
    endtask

    task automatic t_sub_timeout();
        int x, p, pu, dc, sc, ab, oe, rl, tt;
        run_txn(8, 1, RQ_READY, RQ_WAIT, 1'b1, x, p, pu, dc, sc, ab, oe, rl, tt);
        chk("R12", "subsequent timeout stop clock", sc, 8);
        chk("R12", "subsequent timeout words", x, 2);
        chk("R12", "subsequent timeout term", tt, 2);
    endtask

    task automatic t_nohit();
        int x, p, pu, dc, sc, ab, oe, rl, tt;
        run_txn(8, NEVER, RQ_READY, RQ_READY, 1'b0, x, p, pu, dc, sc, ab, oe, rl, tt);
        chk("R2", "no hit devsel", dc, -1);
        chk("R2", "no hit oe", oe, 0);
        chk("R3", "no hit pulses", pu, 0);
    endtask

    // Back-end requests while TRDY# waits on IRDY# must not change the pins.
    task automatic t_hold();
        @(posedge clk); #1;
        be_req = RQ_READY; hit = 1'b1; frame_n = 1'b0; irdy_n = 1'b1;
        @(posedge clk); #1 hit = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1 be_req = RQ_FATAL;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R4", "held trdy", trdy_n, 0);
            chk("R4", "held stop", stop_n, 1);
            chk("R4", "held devsel", devsel_n, 0);
            @(posedge clk); #1;
        end
        irdy_n = 1'b0; frame_n = 1'b1; be_req = RQ_READY;
        @(negedge clk);
        chk("R4", "trdy still low at completion", trdy_n, 0);
        @(posedge clk); #1;
        irdy_n = 1'b1; be_req = RQ_WAIT;
        @(negedge clk);
        chk("R3", "hold done pulse", phase_done, 1);
        chk("R6", "hold release pins", {ctl_oe, trdy_n, stop_n, devsel_n}, 15);
        @(negedge clk);
        chk("R3", "hold pulse one clock", phase_done, 0);
        chk("R6", "hold float", ctl_oe, 0);
        chk("R4", "hold ignored fatal", term_type, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all-requirements: actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_burst(4, "burst");
        idle(2);
        t_burst(1, "single");
        idle(2);
        t_retry();
        idle(2);
        t_disc_data();
        idle(2);
        t_disc_nodata();
        idle(2);
        t_abort(1, 2, 5);
        idle(2);
        t_abort(0, 0, 3);
        idle(2);
        t_burst(3, "after-abort"); // R13: term cleared by new claim
        idle(2);
        t_init_timeout();
        idle(2);
        t_sub_timeout();
        idle(2);
        t_nohit();
        idle(2);
        t_hold();
        idle(2);
        summary();
        $finish;
    end

endmodule